// File: doc/BRIEF.md
# Serial-Probe Pseudo-Associative Cache

This block is a data cache that keeps all its lines in one direct-mapped array, yet places and finds lines as a set-associative cache does. The array of `LINES` entries is divided into `LINES/WAYS` sets. A set is chosen by the address bits just above the line offset, and the slot number within the set forms the top bits of the array index. A lookup reads one slot per cycle, starting at slot 0. It moves to the next slot only when the current one misses, and it stops at the first match. A hit in slot i therefore costs i+1 cycles.

When every slot of the set has missed, the block reads the whole line from next-level memory. It installs the line in the lowest-numbered empty slot of the set. If the set has no empty slot, a round-robin pointer kept for each set picks the slot to replace. Stores are write-allocate and write-through: every store also produces a single-cycle word write toward memory. The block handles one access at a time. Its request ready stays low from acceptance until the response.

Top module: `pseudo_assoc_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` and `mem_rd_valid` are 0, and every line is empty, so the first access to any address misses.
- R2: Probe i reads array index {i, set}, where set is `addr[7:4]` by default. Probes run in order 0,1,..,WAYS-1. A hit found at probe i gives `resp_hit`=1 and `resp_probes`=i+1, and it appears i+1 cycles after the accepting clock edge.
- R3: After WAYS missing probes, exactly one line read is issued, with `mem_rd_addr` = access address with its low 4 bits cleared. It is held until `mem_rd_done`. The response then has `resp_hit`=0 and `resp_probes`=WAYS. A hit issues no line read.
- R4: A refill goes into the lowest-numbered empty slot of the set, so that line is later found with `resp_probes` = that slot + 1.
- R5: With all slots of a set full, the replaced slot comes from a pointer kept for each set. The pointer starts at 0 after reset, and it advances by one on each such replacement in that set only.
- R6: `req_ready` is 0 from the cycle after acceptance until the response cycle. A request presented while `req_ready` is 0 is ignored: it produces no response, no memory write and no change to cached data.
- R7: A load returns the 32-bit word selected by `addr[3:2]` of the line, whether the line hits or is refilled.
- R8: A store updates the cached word (allocating the line on a miss). In the response cycle it pulses `mem_wr_valid` with `mem_wr_addr` = store address and `mem_wr_data` = store data. Loads never pulse `mem_wr_valid`.
- R9: The tag stored with each line covers all address bits above the set field. Addresses that share a set but differ in higher bits occupy different slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | 32 | Load data (store data echoed for stores) |
| resp_hit | output | 1 | Access hit in the array |
| resp_probes | output | $clog2(WAYS+1) | Number of probes the access used |
| mem_rd_valid | output | 1 | Line read request, held until done |
| mem_rd_addr | output | ADDR_W | Line-aligned read address |
| mem_rd_done | input | 1 | Line read data present |
| mem_rd_data | input | LINE_BYTES*8 | Line read data, word 0 in the low bits |
| mem_wr_valid | output | 1 | Write-through strobe |
| mem_wr_addr | output | ADDR_W | Write-through byte address |
| mem_wr_data | output | 32 | Write-through data |

## Verification
On a store miss, the refill data arriving and the store word being merged into that line happen on the same clock edge. The bench provokes this by storing to a cold line and then loading both the stored word and a neighbouring word of the same line as hits. The stored word must read back as the store data, and the neighbour must read back as the memory contents. A second overlap is a new request held high while the block is busy. It is judged by watching that `req_ready` stays low throughout, that no stray response or memory write follows, and that a later load of that address misses with the unmodified memory value.

// File: rtl/pseudo_assoc_cache.sv
module pseudo_assoc_cache #(
  parameter int LINES      = 64,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 16,
  parameter int ADDR_W     = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [31:0]              req_wdata,
  output logic                     resp_valid,
  output logic [31:0]              resp_rdata,
  output logic                     resp_hit,
  output logic [$clog2(WAYS+1)-1:0] resp_probes,
  output logic                     mem_rd_valid,
  output logic [ADDR_W-1:0]        mem_rd_addr,
  input  logic                     mem_rd_done,
  input  logic [LINE_BYTES*8-1:0]  mem_rd_data,
  output logic                     mem_wr_valid,
  output logic [ADDR_W-1:0]        mem_wr_addr,
  output logic [31:0]              mem_wr_data
);
  localparam int WORDS  = LINE_BYTES / 4;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SETS   = LINES / WAYS;
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int IDX_W  = WAY_W + SET_W;
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
  localparam int WSEL_W = $clog2(WORDS);
  localparam int PC_W   = $clog2(WAYS + 1);

  typedef enum logic [1:0] {S_IDLE, S_PROBE, S_FILL} state_t;
  typedef logic [WORDS-1:0][31:0] line_t;

  state_t            state;
  logic [ADDR_W-1:0] a_q;
  logic [31:0]       wd_q;
  logic              wr_q;
  logic [WAY_W-1:0]  p_q;
  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  line_t             data_q [LINES];
  logic [WAY_W-1:0]  rr_q   [SETS];

  logic [SET_W-1:0]  set;
  logic [TAG_W-1:0]  tag;
  logic [WSEL_W-1:0] wsel;
  logic [IDX_W-1:0]  probe_idx, fill_idx;
  logic              hit, last, all_valid;
  logic [WAY_W-1:0]  vic;
  line_t             fill_line;

  assign set       = a_q[OFF_W +: SET_W];
  assign tag       = a_q[ADDR_W-1 -: TAG_W];
  assign wsel      = a_q[2 +: WSEL_W];
  assign probe_idx = {p_q, set};
  assign hit       = valid_q[probe_idx] && (tag_q[probe_idx] == tag);
  assign last      = (p_q == WAY_W'(WAYS - 1));
  assign fill_idx  = {vic, set};

  always_comb begin
    vic = rr_q[set];
    all_valid = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_q[{WAY_W'(w), set}]) begin
        vic = WAY_W'(w);
        all_valid = 1'b0;
      end
    end
  end

  always_comb begin
    fill_line = mem_rd_data;
    if (wr_q) fill_line[wsel] = wd_q;
  end

  assign req_ready    = (state == S_IDLE);
  assign mem_rd_valid = (state == S_FILL);
  assign mem_rd_addr  = {a_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_wr_addr  = a_q;
  assign mem_wr_data  = wd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      a_q          <= '0;
      wd_q         <= '0;
      wr_q         <= 1'b0;
      p_q          <= '0;
      valid_q      <= '0;
      resp_valid   <= 1'b0;
      resp_rdata   <= '0;
      resp_hit     <= 1'b0;
      resp_probes  <= '0;
      mem_wr_valid <= 1'b0;
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else begin
      resp_valid   <= 1'b0;
      mem_wr_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          a_q   <= req_addr;
          wd_q  <= req_wdata;
          wr_q  <= req_write;
          p_q   <= '0;
          state <= S_PROBE;
        end
        S_PROBE: begin
          if (hit) begin
            resp_valid   <= 1'b1;
            resp_hit     <= 1'b1;
            resp_probes  <= PC_W'(p_q) + PC_W'(1);
            resp_rdata   <= wr_q ? wd_q : data_q[probe_idx][wsel];
            mem_wr_valid <= wr_q;
            state        <= S_IDLE;
          end else if (last) begin
            state <= S_FILL;
          end else begin
            p_q <= p_q + WAY_W'(1);
          end
        end
        S_FILL: if (mem_rd_done) begin
          valid_q[fill_idx] <= 1'b1;
          if (all_valid) rr_q[set] <= rr_q[set] + WAY_W'(1);
          resp_valid   <= 1'b1;
          resp_hit     <= 1'b0;
          resp_probes  <= PC_W'(WAYS);
          resp_rdata   <= fill_line[wsel];
          mem_wr_valid <= wr_q;
          state        <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_PROBE && hit && wr_q)
      data_q[probe_idx][wsel] <= wd_q;
    if (state == S_FILL && mem_rd_done) begin
      tag_q[fill_idx]  <= tag;
      data_q[fill_idx] <= fill_line;
    end
  end
endmodule

// File: rtl/pseudo_assoc_cache_chk.sv
module pseudo_assoc_cache_chk #(
  parameter int WAYS   = 4,
  parameter int ADDR_W = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic                      resp_valid,
  input logic                      resp_hit,
  input logic [$clog2(WAYS+1)-1:0] resp_probes,
  input logic                      mem_rd_valid,
  input logic [ADDR_W-1:0]         mem_rd_addr,
  input logic                      mem_rd_done,
  input logic                      mem_wr_valid
);
  assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_resp_follows_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !$past(req_ready));

  assert_probe_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_probes >= 1 && resp_probes <= WAYS));

  assert_miss_full_walk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> (resp_probes == WAYS));

  assert_read_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_done) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  assert_no_read_when_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !req_ready);

  assert_write_with_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> resp_valid);
endmodule

bind pseudo_assoc_cache pseudo_assoc_cache_chk #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_probes(resp_probes),
  .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
  .mem_rd_done(mem_rd_done), .mem_wr_valid(mem_wr_valid)
);

// File: tb/pseudo_assoc_cache_bench.sv
module pseudo_assoc_cache_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [31:0]  req_addr = '0, req_wdata = '0;
  logic         req_ready, resp_valid, resp_hit;
  logic [31:0]  resp_rdata;
  logic [2:0]   resp_probes;
  logic         mem_rd_valid, mem_rd_done = 1'b0;
  logic [31:0]  mem_rd_addr;
  logic [127:0] mem_rd_data = '0;
  logic         mem_wr_valid;
  logic [31:0]  mem_wr_addr, mem_wr_data;

  int errors = 0, checks = 0, rd_cnt = 0, lat_cnt = 0, cycles = 0;
  logic [31:0] last_rd = '0;
  logic [31:0] ref_mem [int unsigned];

  pseudo_assoc_cache u_pseudo_assoc_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_hit(resp_hit),
    .resp_probes(resp_probes), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_done(mem_rd_done), .mem_rd_data(mem_rd_data), .mem_wr_valid(mem_wr_valid),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] ref_word(input logic [31:0] a);
    if (ref_mem.exists(a)) return ref_mem[a];
    return (a * 32'h9E37_79B1) ^ 32'h5EED_0000;
  endfunction

  always @(negedge clk) begin
    mem_rd_done <= 1'b0;
    if (!rst_n) lat_cnt <= 0;
    else if (mem_rd_valid && !mem_rd_done) begin
      if (lat_cnt == 2) begin
        mem_rd_done <= 1'b1;
        lat_cnt <= 0;
        rd_cnt <= rd_cnt + 1;
        last_rd <= mem_rd_addr;
        for (int w = 0; w < 4; w++) mem_rd_data[w*32 +: 32] <= ref_word(mem_rd_addr + 32'(w*4));
      end else lat_cnt <= lat_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 50000);
      finish_run();
    end
  end

  logic [31:0] r_data, r_wa, r_wd;
  logic [2:0]  r_probes;
  logic        r_hit, r_wv;
  int          r_cyc;

  task automatic access(input logic wr, input logic [31:0] addr, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r_cyc = 0;
    for (int k = 0; k < 100; k++) begin
      @(posedge clk);
      r_cyc++;
      @(negedge clk);
      if (resp_valid) break;
    end
    r_data = resp_rdata; r_probes = resp_probes; r_hit = resp_hit;
    r_wv = mem_wr_valid; r_wa = mem_wr_addr; r_wd = mem_wr_data;
  endtask

  // {write, addr, wdata, expected probes, expected hit}; set field = addr[7:4]
  localparam int NV = 21;
  localparam logic [68:0] VEC [NV] = '{
    {1'b0, 32'h0000_1000, 32'h0, 3'd4, 1'b0},
    {1'b0, 32'h0000_1000, 32'h0, 3'd1, 1'b1},
    {1'b0, 32'h0000_2000, 32'h0, 3'd4, 1'b0},
    {1'b0, 32'h0000_2004, 32'h0, 3'd2, 1'b1},
    {1'b0, 32'h0000_3000, 32'h0, 3'd4, 1'b0},
    {1'b0, 32'h0000_4000, 32'h0, 3'd4, 1'b0},
    {1'b0, 32'h0000_4008, 32'h0, 3'd4, 1'b1},
    {1'b0, 32'h0000_5000, 32'h0, 3'd4, 1'b0},
    {1'b0, 32'h0000_500C, 32'h0, 3'd1, 1'b1},
    {1'b0, 32'h0000_1000, 32'h0, 3'd4, 1'b0},
    {1'b0, 32'h0000_1000, 32'h0, 3'd2, 1'b1},
    {1'b0, 32'h0000_3004, 32'h0, 3'd3, 1'b1},
    {1'b0, 32'h0000_2000, 32'h0, 3'd4, 1'b0},
    {1'b0, 32'h0000_2000, 32'h0, 3'd3, 1'b1},
    {1'b0, 32'h0000_1010, 32'h0, 3'd4, 1'b0},
    {1'b0, 32'h0000_1010, 32'h0, 3'd1, 1'b1},
    {1'b1, 32'h0000_4004, 32'hDEAD_BEEF, 3'd4, 1'b1},
    {1'b0, 32'h0000_4004, 32'h0, 3'd4, 1'b1},
    {1'b1, 32'h0000_6020, 32'h1234_5678, 3'd4, 1'b0},
    {1'b0, 32'h0000_6020, 32'h0, 3'd1, 1'b1},
    {1'b0, 32'h0000_6024, 32'h0, 3'd1, 1'b1}
  };

  initial begin
    bit busy_ok;
    int rd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
    chk(resp_valid == 1'b0, "R1 no response in reset", 32'(resp_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_rd_valid == 1'b0, "R1 idle after reset",
        {30'd0, req_ready, mem_rd_valid}, 32'd2);

    for (int i = 0; i < NV; i++) begin
      logic        wr, eh;
      logic [31:0] ad, wd;
      logic [2:0]  ep;
      {wr, ad, wd, ep, eh} = VEC[i];
      rd0 = rd_cnt;
      if (wr) ref_mem[ad] = wd;
      access(wr, ad, wd);
      chk(r_probes == ep, "R4/R5/R9 probe count", 32'(r_probes), 32'(ep));
      chk(r_hit == eh, "R2 hit flag", 32'(r_hit), 32'(eh));
      if (eh) begin
        chk(r_cyc == int'(ep), "R2 hit latency", 32'(r_cyc), 32'(ep));
        chk(rd_cnt == rd0, "R3 no read on hit", 32'(rd_cnt - rd0), 32'd0);
      end else begin
        chk(rd_cnt == rd0 + 1, "R3 one read on miss", 32'(rd_cnt - rd0), 32'd1);
        chk(last_rd == {ad[31:4], 4'h0}, "R3 line address", last_rd, {ad[31:4], 4'h0});
      end
      if (wr) begin
        chk(r_wv && r_wa == ad && r_wd == wd, "R8 write-through", r_wd, wd);
      end else begin
        chk(r_data == ref_word(ad), "R7 load data", r_data, ref_word(ad));
        chk(!r_wv, "R8 no write on load", 32'(r_wv), 32'd0);
      end
    end

    // R6: request held during a busy miss is ignored
    rd0 = rd_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0000_8000;
    @(posedge clk);
    @(negedge clk);
    req_write = 1'b1; req_addr = 32'h0000_7000; req_wdata = 32'hBAD0_BAD0;
    busy_ok = 1'b1;
    for (int k = 0; k < 100; k++) begin
      if (resp_valid) break;
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(busy_ok, "R6 ready low while busy", 32'(busy_ok), 32'd1);
    chk(resp_rdata == ref_word(32'h8000), "R7 busy-case load data", resp_rdata, ref_word(32'h8000));
    repeat (3) begin
      @(negedge clk);
      chk(!resp_valid && !mem_wr_valid, "R6 ignored request silent",
          {30'd0, resp_valid, mem_wr_valid}, 32'd0);
    end
    access(1'b0, 32'h0000_7000, 32'h0);
    chk(r_hit == 1'b0 && r_probes == 3'd4, "R6 ignored address not cached", 32'(r_probes), 32'd4);
    chk(r_data == ref_word(32'h7000), "R6 ignored store not applied", r_data, ref_word(32'h7000));
    chk(rd_cnt == rd0 + 2, "R3 read count busy case", 32'(rd_cnt - rd0), 32'd2);

    // R1: reset clears all lines
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    access(1'b0, 32'h0000_6020, 32'h0);
    chk(r_hit == 1'b0 && r_probes == 3'd4, "R1 lines empty after reset", 32'(r_probes), 32'd4);
    chk(r_data == ref_word(32'h6020), "R7 data after reset refill", r_data, ref_word(32'h6020));

    finish_run();
  end
endmodule